// File: doc/BRIEF.md
# Video Timing Controller Register Port

This block is the processor-side register port of a character-cell video timing controller. The bus has two locations, chosen by a register-select bit. A write to the select location loads a 5-bit index latch. A write to the data location stores the byte into the indexed register. Before storage, each register trims its value to its own field width.

Reads work in the same two ways. The select location returns a status byte that shows whether the scan is in vertical retrace. The data location returns a value only for the few registers that are meant to be read back.

The stored registers drive the timing logic in parallel. The block also decodes the control register into these outputs:
- a 14-bit display start address,
- a screen-offset field,
- a character-set half select,
- a video-invert flag.

A cursor blink-mode field is derived from the cursor configuration register. When the hardware cursor is enabled and this field changes, the blink state restarts.

Top module: `vtc_regport`

## Requirements
- R1: A bus write with `rs_i` = 0 loads the index latch with `wdata_i[4:0]`. A later write with `rs_i` = 1 then lands in that register, as seen on `regs_o`.
- R2: A write with `rs_i` = 1 trims the byte before storage. Registers 4, 6, 7, 10 and 11 keep bits 6:0. Registers 5 and 9 keep bits 4:0. Registers 12 and 14 keep bits 5:0. All other bits read as 0.
- R3: All other registers store all 8 bits unchanged.
- R4: A read with `rs_i` = 0 returns status: bit 5 equals `vretrace_i` sampled at the read strobe, and all other bits are 0.
- R5: A read with `rs_i` = 1 returns the stored value for registers 14 and 15, and 0xFF for registers 16 and 17. All other registers read 0x00.
- R6: `rdata_o` is registered. It updates one clock after a read strobe (`cs_i`=1, `we_i`=0) and holds its value in every other cycle.
- R7: A write to register 10 sets a new cursor mode, equal to `wdata_i[6:5]` XOR 2'b01, under two conditions: `hw_cursor_en_i` = 1, and the new mode differs from the current one. The same write sets `blink_state_o` to 1 and loads `blink_cnt_o` with 16.
- R8: A write to register 10 leaves the cursor mode, blink state and blink counter unchanged in either of two cases: `hw_cursor_en_i` = 0, or the new mode equals the current one.
- R9: The outputs `start_addr_o`, `scr_offset_o`, `chargen_hi_o` and `invert_o` are decoded from registers 12 and 13:
  - `start_addr_o` = {reg12[5:0], reg13}.
  - `scr_offset_o` = reg12[1:0].
  - `chargen_hi_o` = reg12[4].
  - `invert_o` = reg12[5].
- R10: Reset clears all registers, the index latch, the cursor mode, the blink state and the blink counter, and also clears `rdata_o`.
- R11: With `cs_i` = 0, writes and reads have no effect on registers, the index latch or `rdata_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| rs_i | input | 1 | Register select: 0 = index/status, 1 = data |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| vretrace_i | input | 1 | Scan is in vertical retrace |
| hw_cursor_en_i | input | 1 | Hardware cursor present |
| regs_o | output | 32x8 | Stored register values, packed by index |
| start_addr_o | output | 14 | Display start address |
| scr_offset_o | output | 2 | Screen-start offset select |
| chargen_hi_o | output | 1 | Upper character-set half |
| invert_o | output | 1 | Invert video |
| crsr_mode_o | output | 2 | Cursor blink mode |
| blink_state_o | output | 1 | Cursor blink state |
| blink_cnt_o | output | 5 | Cursor blink counter |

## Verification
Each result has a fixed latency from the clock edge that samples the stimulus:
- **Index latch, stored registers and cursor state:** updated at that edge. `regs_o` and the decoded outputs follow with no further delay.
- **Read data:** `rdata_o` is loaded at the edge that samples the read strobe.

The bench applies every input at a falling edge and holds it through exactly one rising edge. It checks at the next falling edge, one half-period after the edge where the result is due.

The hold and chip-select checks look at `rdata_o` and `regs_o` across several idle cycles after the stimulus.

// File: rtl/vtc_pkg.sv
package vtc_pkg;
  localparam int DW     = 8;
  localparam int SEL_W  = 5;
  localparam int NREG   = 1 << SEL_W;

  localparam logic [SEL_W-1:0] REG_CRSR_CFG = 5'd10;
  localparam logic [SEL_W-1:0] REG_CTRL     = 5'd12;
  localparam logic [SEL_W-1:0] REG_START_LO = 5'd13;
  localparam logic [SEL_W-1:0] REG_CPOS_HI  = 5'd14;
  localparam logic [SEL_W-1:0] REG_CPOS_LO  = 5'd15;
  localparam logic [SEL_W-1:0] REG_PEN_HI   = 5'd16;
  localparam logic [SEL_W-1:0] REG_PEN_LO   = 5'd17;

  localparam int STATUS_VR_BIT = 5;

  function automatic logic [DW-1:0] reg_mask(int idx);
    case (idx)
      4, 6, 7, 10, 11: return 8'h7F;
      5, 9:            return 8'h1F;
      12, 14:          return 8'h3F;
      default:         return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/vtc_sel_latch.sv
module vtc_sel_latch
  import vtc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [SEL_W-1:0] idx_i,
  output logic [SEL_W-1:0] sel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sel_o <= '0;
    else if (ld_i) sel_o <= idx_i;
  end

  a_r1_latch_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> sel_o == $past(idx_i));
endmodule

// File: rtl/vtc_reg_bank.sv
module vtc_reg_bank
  import vtc_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_i,
  input  logic [SEL_W-1:0]          sel_i,
  input  logic [DW-1:0]             wdata_i,
  output logic [NREG-1:0][DW-1:0]   regs_o
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [DW-1:0] MASK = reg_mask(i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         regs_o[i] <= '0;
      else if (wr_i && sel_i == SEL_W'(i)) regs_o[i] <= wdata_i & MASK;
    end
  end

  a_r2_reg4_trim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == 5'd4) |=> !regs_o[4][7]);
  a_r11_no_write_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(regs_o));
endmodule

// File: rtl/vtc_cursor_ctl.sv
module vtc_cursor_ctl
  import vtc_pkg::*;
#(
  parameter int BLINK_LOAD = 16,
  localparam int CW = $clog2(BLINK_LOAD + 1)
)(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_wr_i,
  input  logic [1:0]    mode_field_i,
  input  logic          hw_en_i,
  output logic [1:0]    mode_o,
  output logic          blink_state_o,
  output logic [CW-1:0] blink_cnt_o
);
  logic [1:0] mode_new;
  logic       restart;

  assign mode_new = mode_field_i ^ 2'b01;
  assign restart  = cfg_wr_i && hw_en_i && (mode_new != mode_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o        <= '0;
      blink_state_o <= 1'b0;
      blink_cnt_o   <= '0;
    end else if (restart) begin
      mode_o        <= mode_new;
      blink_state_o <= 1'b1;
      blink_cnt_o   <= CW'(BLINK_LOAD);
    end
  end

  a_r7_mode_restarts_blink: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_o) |-> (blink_state_o && blink_cnt_o == CW'(BLINK_LOAD)));
  a_r8_disabled_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hw_en_i |=> ($stable(mode_o) && $stable(blink_state_o) && $stable(blink_cnt_o)));
endmodule

// File: rtl/vtc_read_port.sv
module vtc_read_port
  import vtc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  logic             rs_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             vretrace_i,
  input  logic [DW-1:0]    cpos_hi_i,
  input  logic [DW-1:0]    cpos_lo_i,
  output logic [DW-1:0]    rdata_o
);
  logic [DW-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (!rs_i) begin
      rd_mux[STATUS_VR_BIT] = vretrace_i;
    end else begin
      case (sel_i)
        REG_CPOS_HI:             rd_mux = cpos_hi_i;
        REG_CPOS_LO:             rd_mux = cpos_lo_i;
        REG_PEN_HI, REG_PEN_LO:  rd_mux = '1;
        default:                 rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_mux;
  end

  a_r4_status_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !rs_i) |=> rdata_o == {2'b00, $past(vretrace_i), 5'b00000});
  a_r6_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: rtl/vtc_regport.sv
module vtc_regport
  import vtc_pkg::*;
#(
  parameter int BLINK_LOAD = 16,
  localparam int CW = $clog2(BLINK_LOAD + 1)
)(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cs_i,
  input  logic                    we_i,
  input  logic                    rs_i,
  input  logic [DW-1:0]           wdata_i,
  output logic [DW-1:0]           rdata_o,
  input  logic                    vretrace_i,
  input  logic                    hw_cursor_en_i,
  output logic [NREG-1:0][DW-1:0] regs_o,
  output logic [13:0]             start_addr_o,
  output logic [1:0]              scr_offset_o,
  output logic                    chargen_hi_o,
  output logic                    invert_o,
  output logic [1:0]              crsr_mode_o,
  output logic                    blink_state_o,
  output logic [CW-1:0]           blink_cnt_o
);
  logic             idx_wr, data_wr, rd_stb, cfg_wr;
  logic [SEL_W-1:0] sel;
  logic [DW-1:0]    ctrl;

  assign idx_wr  = cs_i && we_i && !rs_i;
  assign data_wr = cs_i && we_i && rs_i;
  assign rd_stb  = cs_i && !we_i;
  assign cfg_wr  = data_wr && sel == REG_CRSR_CFG;

  vtc_sel_latch u_sel (
    .clk_i, .rst_ni, .ld_i(idx_wr), .idx_i(wdata_i[SEL_W-1:0]), .sel_o(sel)
  );

  vtc_reg_bank u_bank (
    .clk_i, .rst_ni, .wr_i(data_wr), .sel_i(sel), .wdata_i, .regs_o
  );

  vtc_cursor_ctl #(.BLINK_LOAD(BLINK_LOAD)) u_crsr (
    .clk_i, .rst_ni, .cfg_wr_i(cfg_wr), .mode_field_i(wdata_i[6:5]),
    .hw_en_i(hw_cursor_en_i), .mode_o(crsr_mode_o),
    .blink_state_o, .blink_cnt_o
  );

  vtc_read_port u_rd (
    .clk_i, .rst_ni, .rd_i(rd_stb), .rs_i, .sel_i(sel), .vretrace_i,
    .cpos_hi_i(regs_o[REG_CPOS_HI]), .cpos_lo_i(regs_o[REG_CPOS_LO]),
    .rdata_o
  );

  assign ctrl         = regs_o[REG_CTRL];
  assign start_addr_o = {ctrl[5:0], regs_o[REG_START_LO]};
  assign scr_offset_o = ctrl[1:0];
  assign chargen_hi_o = ctrl[4];
  assign invert_o     = ctrl[5];

  a_r9_ctrl_decode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && sel == REG_CTRL) |=> invert_o == $past(wdata_i[5]));
endmodule

// File: tb/tb_vtc_regport.sv
module tb_vtc_regport;
  logic clk = 0, rst_n = 0;
  logic cs = 0, we = 0, rs = 0, vr = 0, hwen = 0;
  logic [7:0] wd = 0;
  logic [7:0] rd;
  logic [31:0][7:0] regs;
  logic [13:0] sa;
  logic [1:0] offs, cmode;
  logic chg, inv, bstate;
  logic [4:0] bcnt;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  vtc_regport dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .we_i(we), .rs_i(rs),
    .wdata_i(wd), .rdata_o(rd), .vretrace_i(vr), .hw_cursor_en_i(hwen),
    .regs_o(regs), .start_addr_o(sa), .scr_offset_o(offs),
    .chargen_hi_o(chg), .invert_o(inv), .crsr_mode_o(cmode),
    .blink_state_o(bstate), .blink_cnt_o(bcnt)
  );

  function automatic logic [7:0] exp_mask(int i);
    case (i)
      4, 6, 7, 10, 11: return 8'h7F;
      5, 9:            return 8'h1F;
      12, 14:          return 8'h3F;
      default:         return 8'hFF;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus(input bit w, input bit s, input logic [7:0] d, input bit sel_cs = 1);
    @(negedge clk);
    cs = sel_cs; we = w; rs = s; wd = d;
    @(negedge clk);
    cs = 0; we = 0; rs = 0; wd = 8'h00;
  endtask

  task automatic wr_reg(input int idx, input logic [7:0] d);
    bus(1, 0, 8'(idx));
    bus(1, 1, d);
  endtask

  task automatic t_reset;
    chk(regs == '0, "R10 regs", 0, 0);
    chk(rd == 8'h00, "R10 rdata", rd, 0);
    chk(cmode == 0 && bstate == 0 && bcnt == 0, "R10 cursor", {cmode, bstate, bcnt}, 0);
    bus(1, 1, 8'hA5);
    chk(regs[0] == 8'hA5, "R10 index latch cleared", regs[0], 8'hA5);
  endtask

  task automatic t_masks;
    for (int i = 1; i < 20; i++) begin
      wr_reg(i, 8'hFF);
      chk(regs[i] == exp_mask(i), (exp_mask(i) == 8'hFF) ? "R3 full store" : "R2 trim", regs[i], exp_mask(i));
    end
    wr_reg(3, 8'h5A);
    chk(regs[3] == 8'h5A, "R1 index then data", regs[3], 8'h5A);
    bus(1, 0, 8'hE7);
    bus(1, 1, 8'h3C);
    chk(regs[7] == 8'h3C, "R1 index low bits", regs[7], 8'h3C);
    chk(regs[9] == 8'h1F, "R2 reg9 kept", regs[9], 8'h1F);
  endtask

  task automatic t_status;
    vr = 1;
    bus(0, 0, 8'h00);
    chk(rd == 8'h20, "R4 status retrace", rd, 8'h20);
    vr = 0;
    bus(0, 0, 8'h00);
    chk(rd == 8'h00, "R4 status idle", rd, 8'h00);
  endtask

  task automatic t_readback;
    wr_reg(14, 8'hD2);
    wr_reg(15, 8'h81);
    bus(0, 1, 8'h00);
    chk(rd == 8'h81, "R5 reg15", rd, 8'h81);
    bus(1, 0, 8'd14); bus(0, 1, 8'h00);
    chk(rd == 8'h12, "R5 reg14", rd, 8'h12);
    bus(1, 0, 8'd16); bus(0, 1, 8'h00);
    chk(rd == 8'hFF, "R5 reg16", rd, 8'hFF);
    bus(1, 0, 8'd17); bus(0, 1, 8'h00);
    chk(rd == 8'hFF, "R5 reg17", rd, 8'hFF);
    bus(1, 0, 8'd3); bus(0, 1, 8'h00);
    chk(rd == 8'h00, "R5 reg3 write-only", rd, 8'h00);
  endtask

  task automatic t_hold;
    bus(1, 0, 8'd16); bus(0, 1, 8'h00);
    vr = 1;
    @(negedge clk); cs = 1; we = 0; rs = 1;
    chk(rd == 8'hFF, "R6 not yet updated", rd, 8'hFF);
    rs = 0;
    @(negedge clk); cs = 0;
    chk(rd == 8'h20, "R6 updated after one clock", rd, 8'h20);
    vr = 0;
    repeat (3) @(negedge clk);
    chk(rd == 8'h20, "R6 hold idle", rd, 8'h20);
  endtask

  task automatic t_cursor;
    hwen = 0;
    wr_reg(10, 8'h40);
    chk(cmode == 0 && bstate == 0 && bcnt == 0, "R8 cursor disabled", {cmode, bstate, bcnt}, 0);
    hwen = 1;
    wr_reg(10, 8'h20);
    chk(cmode == 0 && bstate == 0 && bcnt == 0, "R8 same mode", {cmode, bstate, bcnt}, 0);
    wr_reg(10, 8'h40);
    chk(cmode == 3, "R7 mode xor", cmode, 3);
    chk(bstate == 1 && bcnt == 16, "R7 blink restart", {bstate, bcnt}, {1'b1, 5'd16});
    wr_reg(10, 8'h60);
    chk(cmode == 2, "R7 mode change", cmode, 2);
    hwen = 0;
    wr_reg(10, 8'h00);
    chk(cmode == 2, "R8 disabled keeps mode", cmode, 2);
  endtask

  task automatic t_ctrl;
    wr_reg(12, 8'hE9);
    wr_reg(13, 8'h7C);
    chk(sa == 14'h297C, "R9 start address", sa, 14'h297C);
    chk(offs == 2'b01 && chg == 0 && inv == 1, "R9 ctrl bits", {offs, chg, inv}, 4'b0101);
    wr_reg(12, 8'h12);
    chk(offs == 2'b10 && chg == 1 && inv == 0, "R9 ctrl bits 2", {offs, chg, inv}, 4'b1010);
  endtask

  task automatic t_cs;
    bus(1, 0, 8'd13);
    bus(1, 0, 8'd2, 0);
    bus(1, 1, 8'h11, 0);
    chk(regs[13] == 8'h7C && regs[2] == 8'hFF, "R11 cs low write", regs[13], 8'h7C);
    vr = 1;
    bus(0, 0, 8'h00, 0);
    chk(rd == 8'h20, "R11 cs low read", rd, 8'h20);
    vr = 0;
    bus(1, 1, 8'h44);
    chk(regs[13] == 8'h44, "R11 latch kept", regs[13], 8'h44);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset; t_masks; t_status; t_readback; t_hold; t_cursor; t_ctrl; t_cs;
      end
      begin
        repeat (20000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule